// File: doc/BRIEF.md
# Word Shift and Bit-Manipulation Unit

This is a 32-bit execution unit for an integer pipeline. It handles word shifts by a register amount or by a 5-bit immediate, plus a handful of bit-level operations: counting leading zeros, a bytewise equality mask, and sign extension from a byte or a halfword. It takes a source word, a second operand (which also carries the register shift amount) and a 3-bit operation code. It returns the result one clock later with a valid flag.

The two arithmetic right shifts also produce a carry. The carry reports whether a negative value lost any one-bits. A separate carry-valid flag marks the cycles in which that carry is meaningful. For every other operation the flag stays low, and the surrounding pipeline keeps the carry it already holds.

Top module: `wordshift_bmu`

## Requirements
- R1: `res_valid` is `in_valid` delayed by one clock. `result`, `carry_out` and `carry_valid` are registered alongside it. Reset clears `res_valid`, `carry_valid`, `carry_out` and `result`.
- R2: Operation 3'b000 shifts left and 3'b001 shifts right logically. The shift amount is `opnd_b[5:0]`. If `opnd_b[5]` is set, the result is zero. Otherwise the distance is `opnd_b[4:0]`. Bits 31..6 of `opnd_b` have no effect.
- R3: Operation 3'b010 is an arithmetic right shift by register. When `opnd_b[5]` is set, the result is all ones for a negative `src` and zero otherwise. In that case carry is set only when `src` is negative and any of `src[30:0]` is 1.
- R4: For a partial arithmetic right shift (register amount below 32, or the immediate), carry is set only when `src` is negative and at least one 1 bit was shifted out. Otherwise carry is cleared.
- R5: Operation 3'b011 shifts arithmetically right by `imm_sh`, and `opnd_b` has no effect. An immediate amount of zero returns `src` unchanged with carry cleared.
- R6: Operation 3'b100 counts leading zeros of `src`. It returns 32 for zero, and 31 minus the index of the highest set bit otherwise.
- R7: Operation 3'b101 compares bytes. Each result byte is 8'hFF where the same byte lanes of `src` and `opnd_b` are equal, and 8'h00 where they differ.
- R8: Operation 3'b110 copies `src[7]` into bits 31..8. Operation 3'b111 copies `src[15]` into bits 31..16.
- R9: `carry_valid` is high only for a valid result of operation 3'b010 or 3'b011. Whenever `carry_valid` is low, `carry_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and operation are valid this cycle |
| op | input | 3 | Operation select |
| src | input | 32 | Source word |
| opnd_b | input | 32 | Second operand / register shift amount |
| imm_sh | input | 5 | Immediate shift amount |
| res_valid | output | 1 | Result valid |
| result | output | 32 | Registered result |
| carry_out | output | 1 | Carry from arithmetic right shifts |
| carry_valid | output | 1 | Carry output is meaningful |

## Verification
The hardest cases to reach are those at the edges of the carry. A negative word shifted out completely with only the sign bit set must give no carry. The same shift with a low bit set must give carry. A negative value whose shifted-out bits are all zero must also give no carry. The stimulus builds each of these operands directly. It also pairs an immediate shift with an `opnd_b` that has bit 5 set, to show that the register amount is ignored. Further operands set `opnd_b` bits above bit 5 while bit 5 is clear, so that a decode of too many amount bits shows up.

// File: rtl/wordshift_bmu.sv
module wordshift_bmu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [2:0]  op,
  input  logic [31:0] src,
  input  logic [31:0] opnd_b,
  input  logic [4:0]  imm_sh,
  output logic        res_valid,
  output logic [31:0] result,
  output logic        carry_out,
  output logic        carry_valid
);
  localparam logic [2:0] OP_SHL  = 3'b000;
  localparam logic [2:0] OP_SHR  = 3'b001;
  localparam logic [2:0] OP_SRAR = 3'b010;
  localparam logic [2:0] OP_SRAI = 3'b011;
  localparam logic [2:0] OP_CLZ  = 3'b100;
  localparam logic [2:0] OP_BEQ  = 3'b101;
  localparam logic [2:0] OP_SXB  = 3'b110;
  localparam logic [2:0] OP_SXH  = 3'b111;

  logic [4:0]  reg_dist;
  logic        shift_out;
  logic [4:0]  sra_dist;
  logic        sra_full;
  logic [31:0] sra_val;
  logic [31:0] lost_mask;
  logic        sra_carry;
  logic        is_sra;
  logic [5:0]  lz_cnt;
  logic [31:0] beq_val;
  logic [31:0] nxt;

  assign reg_dist  = opnd_b[4:0];
  assign shift_out = opnd_b[5];

  assign sra_dist  = (op == OP_SRAI) ? imm_sh : reg_dist;
  assign sra_full  = (op == OP_SRAR) && shift_out;
  assign sra_val   = sra_full ? {32{src[31]}} : 32'($signed(src) >>> sra_dist);
  assign lost_mask = (32'h1 << sra_dist) - 32'h1;
  assign sra_carry = src[31] & (sra_full ? (|src[30:0]) : (|(src & lost_mask)));
  assign is_sra    = (op == OP_SRAR) || (op == OP_SRAI);

  always_comb begin
    lz_cnt = 6'd32;
    for (int i = 0; i < 32; i++)
      if (src[i]) lz_cnt = 6'(31 - i);
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign beq_val[8*g +: 8] = (src[8*g +: 8] == opnd_b[8*g +: 8]) ? 8'hFF : 8'h00;
  end

  always_comb begin
    unique case (op)
      OP_SHL:  nxt = shift_out ? 32'h0 : src << reg_dist;
      OP_SHR:  nxt = shift_out ? 32'h0 : src >> reg_dist;
      OP_SRAR,
      OP_SRAI: nxt = sra_val;
      OP_CLZ:  nxt = {26'h0, lz_cnt};
      OP_BEQ:  nxt = beq_val;
      OP_SXB:  nxt = {{24{src[7]}}, src[7:0]};
      OP_SXH:  nxt = {{16{src[15]}}, src[15:0]};
      default: nxt = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      result      <= 32'h0;
      carry_out   <= 1'b0;
      carry_valid <= 1'b0;
    end else begin
      res_valid   <= in_valid;
      carry_valid <= in_valid && is_sra;
      if (in_valid) begin
        result    <= nxt;
        carry_out <= is_sra && sra_carry;
      end else begin
        carry_out <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wordshift_bmu_chk.sv
module wordshift_bmu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [2:0]  op,
  input logic [31:0] src,
  input logic [31:0] opnd_b,
  input logic [4:0]  imm_sh,
  input logic        res_valid,
  input logic [31:0] result,
  input logic        carry_out,
  input logic        carry_valid
);
  a_r1_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  a_r1_idle_delay: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);
  a_r9_carry_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_valid |-> !carry_out);
  a_r9_carry_only_sra: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (carry_valid == ($past(op) == 3'b010 || $past(op) == 3'b011)));
  a_r4_carry_negative: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_valid && carry_out) |-> result[31]);
  a_r5_imm_zero_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(op == 3'b011 && imm_sh == 5'd0))
      |-> (result == $past(src) && !carry_out));
  a_r6_clz_range: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(op) == 3'b100) |-> (result <= 32'd32));
  a_r7_lane_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(op) == 3'b101)
      |-> ((result[7:0] == 8'h00 || result[7:0] == 8'hFF) &&
           (result[15:8] == 8'h00 || result[15:8] == 8'hFF) &&
           (result[23:16] == 8'h00 || result[23:16] == 8'hFF) &&
           (result[31:24] == 8'h00 || result[31:24] == 8'hFF)));
endmodule

bind wordshift_bmu wordshift_bmu_chk chk_i (.*);

// File: tb/wordshift_bmu_tb_top.sv
`timescale 1ns/1ps
module wordshift_bmu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = 3'b000;
  logic [31:0] src = 32'h0;
  logic [31:0] opnd_b = 32'h0;
  logic [4:0]  imm_sh = 5'd0;
  logic        res_valid;
  logic [31:0] result;
  logic        carry_out;
  logic        carry_valid;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wordshift_bmu dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .src(src), .opnd_b(opnd_b), .imm_sh(imm_sh), .res_valid(res_valid),
    .result(result), .carry_out(carry_out), .carry_valid(carry_valid));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(string req, logic [2:0] o, logic [31:0] a, logic [31:0] b,
                        logic [4:0] im, logic [31:0] exp_res, logic exp_cy, logic exp_cv);
    @(negedge clk);
    op = o; src = a; opnd_b = b; imm_sh = im; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, "res_valid", 32'(res_valid), 32'd1);
    chk(req, "result", result, exp_res);
    chk(req, "carry_valid", 32'(carry_valid), 32'(exp_cv));
    chk(req, "carry_out", 32'(carry_out), 32'(exp_cy));
  endtask

  task automatic t_reset();
    chk("R1", "reset res_valid", 32'(res_valid), 32'd0);
    chk("R1", "reset carry_valid", 32'(carry_valid), 32'd0);
    chk("R1", "reset result", result, 32'd0);
  endtask

  task automatic t_logical();
    run_op("R2", 3'b000, 32'h8000_0001, 32'd4, 5'd0, 32'h0000_0010, 1'b0, 1'b0);
    run_op("R2", 3'b000, 32'hFFFF_FFFF, 32'h20, 5'd0, 32'h0, 1'b0, 1'b0);
    run_op("R2", 3'b000, 32'h0000_0001, 32'hFFFF_FFC1, 5'd0, 32'h0000_0002, 1'b0, 1'b0);
    run_op("R2", 3'b001, 32'h8000_0000, 32'd31, 5'd0, 32'h0000_0001, 1'b0, 1'b0);
    run_op("R2", 3'b001, 32'hFFFF_FFFF, 32'h3F, 5'd0, 32'h0, 1'b0, 1'b0);
    run_op("R2", 3'b001, 32'hF000_0000, 32'h0000_0144, 5'd0, 32'h0F00_0000, 1'b0, 1'b0);
  endtask

  task automatic t_sra_full();
    run_op("R3", 3'b010, 32'h8000_0000, 32'h20, 5'd0, 32'hFFFF_FFFF, 1'b0, 1'b1);
    run_op("R3", 3'b010, 32'h8000_0001, 32'h20, 5'd0, 32'hFFFF_FFFF, 1'b1, 1'b1);
    run_op("R3", 3'b010, 32'h7FFF_FFFF, 32'h25, 5'd0, 32'h0, 1'b0, 1'b1);
  endtask

  task automatic t_sra_partial();
    run_op("R4", 3'b010, 32'hF000_0001, 32'd1, 5'd0, 32'hF800_0000, 1'b1, 1'b1);
    run_op("R4", 3'b010, 32'hF000_0000, 32'd4, 5'd0, 32'hFF00_0000, 1'b0, 1'b1);
    run_op("R4", 3'b010, 32'h7000_0001, 32'd1, 5'd0, 32'h3800_0000, 1'b0, 1'b1);
    run_op("R4", 3'b010, 32'h8000_0004, 32'd0, 5'd0, 32'h8000_0004, 1'b0, 1'b1);
  endtask

  task automatic t_sra_imm();
    run_op("R5", 3'b011, 32'h8000_0003, 32'h0000_0020, 5'd0, 32'h8000_0003, 1'b0, 1'b1);
    run_op("R5", 3'b011, 32'h8000_0003, 32'h0000_0020, 5'd2, 32'hE000_0000, 1'b1, 1'b1);
    run_op("R4", 3'b011, 32'h8000_0010, 32'd0, 5'd4, 32'hF800_0001, 1'b0, 1'b1);
  endtask

  task automatic t_clz();
    run_op("R6", 3'b100, 32'h0, 32'h0, 5'd0, 32'd32, 1'b0, 1'b0);
    run_op("R6", 3'b100, 32'h1, 32'h0, 5'd0, 32'd31, 1'b0, 1'b0);
    run_op("R6", 3'b100, 32'h8000_0000, 32'h0, 5'd0, 32'd0, 1'b0, 1'b0);
    run_op("R6", 3'b100, 32'h0001_FFFF, 32'h0, 5'd0, 32'd15, 1'b0, 1'b0);
  endtask

  task automatic t_bytes();
    run_op("R7", 3'b101, 32'h1122_3344, 32'h11AA_33BB, 5'd0, 32'hFF00_FF00, 1'b0, 1'b0);
    run_op("R7", 3'b101, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 5'd0, 32'hFFFF_FFFF, 1'b0, 1'b0);
    run_op("R7", 3'b101, 32'h0000_0000, 32'h0101_0101, 5'd0, 32'h0000_0000, 1'b0, 1'b0);
  endtask

  task automatic t_sext();
    run_op("R8", 3'b110, 32'h1234_5680, 32'h0, 5'd0, 32'hFFFF_FF80, 1'b0, 1'b0);
    run_op("R8", 3'b110, 32'hFFFF_FF7F, 32'h0, 5'd0, 32'h0000_007F, 1'b0, 1'b0);
    run_op("R8", 3'b111, 32'hABCD_8001, 32'h0, 5'd0, 32'hFFFF_8001, 1'b0, 1'b0);
    run_op("R8", 3'b111, 32'hFF12_7FFF, 32'h0, 5'd0, 32'h0000_7FFF, 1'b0, 1'b0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    op = 3'b010; src = 32'h8000_0001; opnd_b = 32'h20; in_valid = 1'b0;
    @(negedge clk);
    chk("R1", "idle res_valid", 32'(res_valid), 32'd0);
    chk("R9", "idle carry_valid", 32'(carry_valid), 32'd0);
    chk("R9", "idle carry_out", 32'(carry_out), 32'd0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_logical();
    t_sra_full();
    t_sra_partial();
    t_sra_imm();
    t_clz();
    t_bytes();
    t_sext();
    t_idle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule